// File: doc/BRIEF.md
# IDE Channel Port Access Decoder

This block sits between a host I/O bus and the drive-facing task-file interface of one IDE channel. The host presents a read or a write aimed at either the channel's command block or its control block. Each request carries a byte offset, an access size of one, two or four bytes, and little-endian write data in the low byte lanes. The decoder decides whether that offset and size pair is a legal access. A legal access becomes exactly one single-cycle strobe toward the drive side: a task-file register byte, a 16-bit data-port transfer, a 32-bit data-port transfer, a device-control write or an alternate-status read.

An access that is not legal is absorbed. A rejected write leaves every drive-side strobe low. A rejected read returns all ones, sized to the access width. Every read, accepted or rejected, returns its data with the same fixed latency and a one-cycle valid flag, so the host side never has to tell the two cases apart.

Top module: `ide_port_decoder`

## Requirements
- R1: A command-block access (host_ctrl_sel = 0) with size code 0 (one byte) at any offset raises tf_rd or tf_wr with tf_addr equal to that offset and, for a write, drv_wdata[7:0] equal to host_wdata[7:0]. The read returns tf_rdata zero-extended to 32 bits.
- R2: A command-block access with size code 1 (two bytes) at offset 0 raises dp16_rd or dp16_wr and, for a write, carries host_wdata[15:0] on drv_wdata[15:0]. The read returns dp16_rdata zero-extended.
- R3: A command-block access with size code 2 (four bytes) at offset 0 raises dp32_rd or dp32_wr and, for a write, carries all 32 bits of host_wdata on drv_wdata. The read returns dp32_rdata.
- R4: A two- or four-byte command-block access at a nonzero offset raises no strobe. Its read returns 0x0000FFFF for size code 1 and 0xFFFFFFFF for size code 2.
- R5: A control-block access (host_ctrl_sel = 1) with size code 0 at offset 2 raises altstat_rd for a read, which returns altstat_rdata zero-extended. For a write it raises devctl_wr with host_wdata[7:0] on drv_wdata[7:0].
- R6: Any other control-block access raises no strobe. Its read returns all ones of the access width: 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for size codes 0, 1 and 2.
- R7: Size code 3 is reserved. Such an access is rejected in either region and its read returns 0xFFFFFFFF.
- R8: An accepted access raises exactly one strobe, high for exactly the one cycle after the request cycle. A rejected access raises none.
- R9: Every read sets host_rvalid for one cycle, two cycles after the request and so one cycle after its strobe, with host_rdata valid in that cycle. A write never sets host_rvalid.
- R10: While rst_n is low, all strobes, host_rvalid and host_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | One-cycle read request |
| host_wr | input | 1 | One-cycle write request |
| host_ctrl_sel | input | 1 | 0 selects the command block, 1 the control block |
| host_off | input | 3 | Byte offset inside the selected block |
| host_size | input | 2 | Access size code: 0 one byte, 1 two bytes, 2 four bytes, 3 reserved |
| host_wdata | input | 32 | Write data, little-endian in the low lanes |
| host_rdata | output | 32 | Read data returned to the host |
| host_rvalid | output | 1 | host_rdata is valid this cycle |
| tf_rd | output | 1 | Task-file register byte read strobe |
| tf_wr | output | 1 | Task-file register byte write strobe |
| tf_addr | output | 3 | Task-file register index |
| drv_wdata | output | 32 | Write data toward the drive |
| tf_rdata | input | 8 | Task-file register read data |
| dp16_rd | output | 1 | 16-bit data-port read strobe |
| dp16_wr | output | 1 | 16-bit data-port write strobe |
| dp16_rdata | input | 16 | 16-bit data-port read data |
| dp32_rd | output | 1 | 32-bit data-port read strobe |
| dp32_wr | output | 1 | 32-bit data-port write strobe |
| dp32_rdata | input | 32 | 32-bit data-port read data |
| devctl_wr | output | 1 | Device-control write strobe |
| altstat_rd | output | 1 | Alternate-status read strobe |
| altstat_rdata | input | 8 | Alternate-status read data |

## Verification
The assertions assume that host_rd and host_wr are never high in the same cycle, and that both stay low during reset. They also assume the drive side holds its read data steady during a read strobe. The stimulus issues one request at a time and keeps both requests low between accesses. It draws the region, offset, size code and direction from a seeded $urandom, adds directed accesses at the legal corners and at the reserved size code, and drives constant drive-side read data so that each returned value can be traced to its source.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

    // Size codes presented by the host
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Outcome of decoding one host access
    typedef enum logic [2:0] {
        ACC_REJECT = 3'd0,
        ACC_TASKF  = 3'd1,
        ACC_DP16   = 3'd2,
        ACC_DP32   = 3'd3,
        ACC_CTRL   = 3'd4
    } acc_kind_e;

    // Number of byte lanes touched by a size code (reserved code counts as full width)
    function automatic logic [2:0] size_lanes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_lanes = 3'd1;
            SZ_HALF: size_lanes = 3'd2;
            default: size_lanes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/ide_acc_classify.sv
module ide_acc_classify
    import ide_dec_pkg::*;
#(
    parameter int OFF_W    = 3,
    parameter int CTRL_OFF = 2
) (
    input  logic             ctrl_sel,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    output acc_kind_e        kind
);
    localparam logic [OFF_W-1:0] CTRL_HIT = OFF_W'(CTRL_OFF);
    localparam logic [OFF_W-1:0] ZERO_OFF = '0;

    always_comb begin
        kind = ACC_REJECT;
        if (ctrl_sel) begin
            // control block: a single byte at one offset only
            if (size == SZ_BYTE && off == CTRL_HIT) begin
                kind = ACC_CTRL;
            end
        end else begin
            case (size)
                SZ_BYTE: kind = ACC_TASKF;
                SZ_HALF: kind = (off == ZERO_OFF) ? ACC_DP16 : ACC_REJECT;
                SZ_WORD: kind = (off == ZERO_OFF) ? ACC_DP32 : ACC_REJECT;
                default: kind = ACC_REJECT;
            endcase
        end
    end
endmodule

// File: rtl/ide_rdata_sel.sv
module ide_rdata_sel
    import ide_dec_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          tf_hit,
    input  logic          dp16_hit,
    input  logic          dp32_hit,
    input  logic          alt_hit,
    input  logic [1:0]    size,
    input  logic [7:0]    tf_data,
    input  logic [15:0]   dp16_data,
    input  logic [DW-1:0] dp32_data,
    input  logic [7:0]    alt_data,
    output logic [DW-1:0] rdata
);
    localparam int NLANE = DW / 8;

    logic [DW-1:0] ones_fill;
    logic [2:0]    lanes;

    assign lanes = size_lanes(size);

    // all-ones response covering only the lanes of the access width
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign ones_fill[g*8 +: 8] = (3'(g) < lanes) ? 8'hFF : 8'h00;
    end

    always_comb begin
        if (tf_hit) begin
            rdata = DW'(tf_data);
        end else if (dp16_hit) begin
            rdata = DW'(dp16_data);
        end else if (dp32_hit) begin
            rdata = dp32_data;
        end else if (alt_hit) begin
            rdata = DW'(alt_data);
        end else begin
            rdata = ones_fill;
        end
    end
endmodule

// File: rtl/ide_port_decoder.sv
module ide_port_decoder
    import ide_dec_pkg::*;
#(
    parameter int OFF_W    = 3,
    parameter int CTRL_OFF = 2,
    parameter int DW       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic             host_ctrl_sel,
    input  logic [OFF_W-1:0] host_off,
    input  logic [1:0]       host_size,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic             host_rvalid,
    output logic             tf_rd,
    output logic             tf_wr,
    output logic [OFF_W-1:0] tf_addr,
    output logic [DW-1:0]    drv_wdata,
    input  logic [7:0]       tf_rdata,
    output logic             dp16_rd,
    output logic             dp16_wr,
    input  logic [15:0]      dp16_rdata,
    output logic             dp32_rd,
    output logic             dp32_wr,
    input  logic [DW-1:0]    dp32_rdata,
    output logic             devctl_wr,
    output logic             altstat_rd,
    input  logic [7:0]       altstat_rdata
);
    typedef struct packed {
        logic             tf_rd;
        logic             tf_wr;
        logic             dp16_rd;
        logic             dp16_wr;
        logic             dp32_rd;
        logic             dp32_wr;
        logic             dev_wr;
        logic             alt_rd;
        logic [OFF_W-1:0] addr;
        logic [DW-1:0]    wdata;
        logic             rd_pend;
        logic [1:0]       size;
        logic             rvalid;
        logic [DW-1:0]    rdata;
    } dec_state_t;

    dec_state_t st_d, st_q;
    acc_kind_e  kind;
    logic       rd_req, wr_req;
    logic [DW-1:0] sel_rdata;

    // read wins if both are raised; the host is expected never to do so
    assign rd_req = host_rd;
    assign wr_req = host_wr & ~host_rd;

    ide_acc_classify #(
        .OFF_W    (OFF_W),
        .CTRL_OFF (CTRL_OFF)
    ) u_classify (
        .ctrl_sel (host_ctrl_sel),
        .off      (host_off),
        .size     (host_size),
        .kind     (kind)
    );

    ide_rdata_sel #(
        .DW (DW)
    ) u_rdata (
        .tf_hit    (st_q.tf_rd),
        .dp16_hit  (st_q.dp16_rd),
        .dp32_hit  (st_q.dp32_rd),
        .alt_hit   (st_q.alt_rd),
        .size      (st_q.size),
        .tf_data   (tf_rdata),
        .dp16_data (dp16_rdata),
        .dp32_data (dp32_rdata),
        .alt_data  (altstat_rdata),
        .rdata     (sel_rdata)
    );

    always_comb begin
        st_d = st_q;
        // stage one: strobes live for one cycle only
        st_d.tf_rd   = rd_req && kind == ACC_TASKF;
        st_d.tf_wr   = wr_req && kind == ACC_TASKF;
        st_d.dp16_rd = rd_req && kind == ACC_DP16;
        st_d.dp16_wr = wr_req && kind == ACC_DP16;
        st_d.dp32_rd = rd_req && kind == ACC_DP32;
        st_d.dp32_wr = wr_req && kind == ACC_DP32;
        st_d.dev_wr  = wr_req && kind == ACC_CTRL;
        st_d.alt_rd  = rd_req && kind == ACC_CTRL;
        st_d.rd_pend = rd_req;
        if (rd_req || wr_req) begin
            st_d.addr = host_off;
            st_d.size = host_size;
        end
        if (wr_req) begin
            st_d.wdata = host_wdata;
        end
        // stage two: return read data one cycle after the strobe
        st_d.rvalid = st_q.rd_pend;
        if (st_q.rd_pend) begin
            st_d.rdata = sel_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tf_rd       = st_q.tf_rd;
    assign tf_wr       = st_q.tf_wr;
    assign tf_addr     = st_q.addr;
    assign drv_wdata   = st_q.wdata;
    assign dp16_rd     = st_q.dp16_rd;
    assign dp16_wr     = st_q.dp16_wr;
    assign dp32_rd     = st_q.dp32_rd;
    assign dp32_wr     = st_q.dp32_wr;
    assign devctl_wr   = st_q.dev_wr;
    assign altstat_rd  = st_q.alt_rd;
    assign host_rvalid = st_q.rvalid;
    assign host_rdata  = st_q.rdata;

    // ---------------- assertions ----------------
    logic [7:0] strobes;
    assign strobes = {tf_rd, tf_wr, dp16_rd, dp16_wr, dp32_rd, dp32_wr, devctl_wr, altstat_rd};

    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    a_r8_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes != 8'h00) |-> $past(host_rd || host_wr));

    a_r9_rvalid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> ##1 host_rvalid);

    a_r9_rvalid_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_rd, 2));

    a_r4_wide_offset_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd || host_wr) && !host_ctrl_sel && host_size != SZ_BYTE && host_off != '0)
        |=> strobes == 8'h00);

    a_r6_ctrl_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd || host_wr) && host_ctrl_sel &&
         !(host_size == SZ_BYTE && host_off == OFF_W'(CTRL_OFF)))
        |=> strobes == 8'h00);

    a_r1_taskfile_index: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_rd || tf_wr) |-> tf_addr == $past(host_off));

endmodule

// File: tb/ide_port_decoder_tb.sv
module ide_port_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd = 1'b0, host_wr = 1'b0, host_ctrl_sel = 1'b0;
    logic [2:0]  host_off = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata, drv_wdata, dp32_rdata;
    logic        host_rvalid, tf_rd, tf_wr, dp16_rd, dp16_wr, dp32_rd, dp32_wr;
    logic        devctl_wr, altstat_rd;
    logic [2:0]  tf_addr;
    logic [7:0]  tf_rdata, altstat_rdata;
    logic [15:0] dp16_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    // drive-side models: fixed data, task file tagged by index
    assign tf_rdata      = 8'hC0 | {5'd0, tf_addr};
    assign dp16_rdata    = 16'h1DE5;
    assign dp32_rdata    = 32'h8A4C_3E71;
    assign altstat_rdata = 8'h5A;

    ide_port_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
        .host_ctrl_sel(host_ctrl_sel), .host_off(host_off), .host_size(host_size),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_addr(tf_addr), .drv_wdata(drv_wdata),
        .tf_rdata(tf_rdata), .dp16_rd(dp16_rd), .dp16_wr(dp16_wr), .dp16_rdata(dp16_rdata),
        .dp32_rd(dp32_rd), .dp32_wr(dp32_wr), .dp32_rdata(dp32_rdata),
        .devctl_wr(devctl_wr), .altstat_rd(altstat_rd), .altstat_rdata(altstat_rdata)
    );

    function automatic logic [7:0] strobe_vec();
        return {tf_rd, tf_wr, dp16_rd, dp16_wr, dp32_rd, dp32_wr, devctl_wr, altstat_rd};
    endfunction

    // expected strobe, bit order {tf_rd,tf_wr,dp16_rd,dp16_wr,dp32_rd,dp32_wr,devctl_wr,altstat_rd}
    function automatic logic [7:0] exp_strobe(input logic c, input logic [2:0] o,
                                              input logic [1:0] s, input logic w);
        if (c) begin
            if (s == 2'd0 && o == 3'd2) return w ? 8'b0000_0010 : 8'b0000_0001;
            return 8'h00;
        end
        if (s == 2'd0) return w ? 8'b0100_0000 : 8'b1000_0000;
        if (s == 2'd1 && o == 3'd0) return w ? 8'b0001_0000 : 8'b0010_0000;
        if (s == 2'd2 && o == 3'd0) return w ? 8'b0000_0100 : 8'b0000_1000;
        return 8'h00;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic c, input logic [2:0] o,
                                              input logic [1:0] s);
        logic [7:0] st;
        st = exp_strobe(c, o, s, 1'b0);
        if (st[7]) return {24'd0, 8'hC0 | {5'd0, o}};
        if (st[5]) return {16'd0, 16'h1DE5};
        if (st[3]) return 32'h8A4C_3E71;
        if (st[0]) return 32'h0000_005A;
        case (s)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic string req_of(input logic c, input logic [2:0] o, input logic [1:0] s);
        if (s == 2'd3) return "R7";
        if (c) return (s == 2'd0 && o == 3'd2) ? "R5" : "R6";
        if (s == 2'd0) return "R1";
        if (o != 3'd0) return "R4";
        return (s == 2'd1) ? "R2" : "R3";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic c, input logic [2:0] o, input logic [1:0] s,
                          input logic w, input logic [31:0] d);
        logic [7:0]  es;
        string       rq;
        logic [31:0] wmask;
        es = exp_strobe(c, o, s, w);
        rq = req_of(c, o, s);
        wmask = (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        @(negedge clk);
        host_ctrl_sel = c; host_off = o; host_size = s; host_wdata = d;
        host_rd = ~w; host_wr = w;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        // one cycle after the request: the strobe (R8)
        check(rq, "strobe", {24'd0, strobe_vec()}, {24'd0, es});
        if (es[7] || es[6]) check("R1", "tf_addr", {29'd0, tf_addr}, {29'd0, o});
        if (w && es != 8'h00) check(rq, "drv_wdata", drv_wdata & wmask, d & wmask);
        check("R9", "early rvalid", {31'd0, host_rvalid}, 32'd0);
        @(negedge clk);
        // two cycles after: strobe gone, read data back (R9)
        check("R8", "strobe width", {24'd0, strobe_vec()}, 32'd0);
        check("R9", "rvalid", {31'd0, host_rvalid}, {31'd0, ~w});
        if (!w) check(rq, "rdata", host_rdata, exp_rdata(c, o, s));
        @(negedge clk);
        check("R9", "rvalid width", {31'd0, host_rvalid}, 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20417;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "strobes in reset", {24'd0, strobe_vec()}, 32'd0);
        check("R10", "rvalid in reset", {31'd0, host_rvalid}, 32'd0);
        check("R10", "rdata in reset", host_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        access(1'b0, 3'd7, 2'd0, 1'b0, 32'h0);            // R1 read, top offset
        access(1'b0, 3'd3, 2'd0, 1'b1, 32'h1234_56A7);    // R1 write
        access(1'b0, 3'd0, 2'd1, 1'b0, 32'h0);            // R2 read
        access(1'b0, 3'd0, 2'd1, 1'b1, 32'hFFFF_BEEF);    // R2 write
        access(1'b0, 3'd0, 2'd2, 1'b0, 32'h0);            // R3 read
        access(1'b0, 3'd0, 2'd2, 1'b1, 32'hDEAD_0042);    // R3 write
        access(1'b0, 3'd1, 2'd1, 1'b0, 32'h0);            // R4 half read
        access(1'b0, 3'd4, 2'd2, 1'b0, 32'h0);            // R4 word read
        access(1'b0, 3'd2, 2'd2, 1'b1, 32'h0BAD_0BAD);    // R4 write dropped
        access(1'b1, 3'd2, 2'd0, 1'b0, 32'h0);            // R5 alt status
        access(1'b1, 3'd2, 2'd0, 1'b1, 32'h0000_0006);    // R5 device control
        access(1'b1, 3'd3, 2'd0, 1'b0, 32'h0);            // R6 byte elsewhere
        access(1'b1, 3'd2, 2'd1, 1'b0, 32'h0);            // R6 half at 2
        access(1'b1, 3'd0, 2'd2, 1'b0, 32'h0);            // R6 word at 0
        access(1'b1, 3'd2, 2'd1, 1'b1, 32'h0000_FFFF);    // R6 write dropped
        access(1'b0, 3'd0, 2'd3, 1'b0, 32'h0);            // R7 reserved size
        access(1'b1, 3'd2, 2'd3, 1'b1, 32'h0000_0004);    // R7 reserved write

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic c, w;
            logic [2:0] o;
            logic [1:0] s;
            c = 1'($urandom);
            w = 1'($urandom);
            o = ($urandom % 4 == 0) ? 3'd0 : 3'($urandom);
            s = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
            access(c, o, s, w, $urandom);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule